// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block turns the 6-bit mode/register field of an instruction operand into an addressing class. For every class it reports a register number, a set of class flags and the values carried in the 16-bit extension words that follow the opcode. Displacements and absolute addresses arrive sign-extended to 32 bits. Immediate operands arrive packed into up to three 32-bit words.

A decode begins with a one-cycle `start` pulse, which presents the field and the operand size in bytes. The block then pulls exactly as many extension words as the mode calls for. It takes them from a stream with a valid/ready handshake. It ends with a one-cycle `done` pulse that carries the number of bytes consumed. An illegal field ends the decode with an `err` pulse instead. Indexed modes only flag the class: their extension word is left on the stream for a separate index block. Memory accesses are made elsewhere.

Top module: `ea_decoder`

Flag bits of `ea_flags`: bit 0 register direct, bit 1 immediate, bit 2 absolute, bit 3 displacement, bit 4 indexed, bit 5 program-counter relative, bit 6 post-increment, bit 7 pre-decrement.

## Requirements
- R1: When field bits [5:4] are 00, the decode is register direct. `reg_num` equals field bits [3:0] (0-7 data, 8-15 address registers), only flag bit 0 is set, no words are taken, and `ext_bytes` is 0.
- R2: Field 111100 is tested before every other mode. It sets only flag bit 1 and reports `reg_num` = 4.
- R3: For modes 2 to 6 (field bits [5:3]), `reg_num` is 8 plus field bits [2:0]. Mode 2 sets no flag. Mode 3 sets bit 6. Mode 4 sets bit 7. Mode 5 sets bit 3 and takes one word. Mode 6 sets bit 4 and takes no word.
- R4: In mode 7, `reg_num` is field bits [2:0]. Reg 0 sets bit 2 and takes one word. Reg 1 sets bit 2 and takes two words. Reg 2 sets bits 5 and 3 and takes one word. Reg 3 sets bits 5 and 4 and takes no word.
- R5: Mode 7 with reg 5, 6 or 7 raises `err` for one cycle instead of `done`. It takes no words, and `reg_num`, `ea_flags`, `disp`, `imm_data` and `ext_bytes` are all zero.
- R6: A one-word displacement or absolute address appears on `disp` sign-extended from 16 bits. A two-word absolute address is the first word (upper half) joined to the second word. Classes without such a value leave `disp` at zero.
- R7: An immediate of size 0 to 2 takes one word. Size 0 or 1 sign-extends the word's low 8 bits, and size 2 sign-extends all 16 bits. The result lands in `imm_data[31:0]` and the upper words are zero.
- R8: An immediate larger than 2 bytes takes 32-bit groups of two words, with the first word as the upper half. Sizes up to 4 take one group, sizes 5 to 8 take two, and larger sizes take three. Group k lands in `imm_data[32k+31:32k]` and unused groups are zero.
- R9: A word is consumed only in a cycle where `ext_valid` and `ext_ready` are both high. `ext_ready` is high only while words are still owed. Valid words outside a decode are ignored, and gaps in `ext_valid` only stretch the decode.
- R10: `done` pulses for one cycle. It comes one cycle after the last word is consumed, or one cycle after `start` when no word is needed. At that point `ext_bytes` equals twice the words taken. A `start` raised while words are still owed is ignored.
- R11: A synchronous active-low reset clears `done`, `err`, `ext_ready` and every result output to zero.
- R12: After `done` or `err`, all result outputs hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a decode of `mode_reg` and `op_size` |
| mode_reg | input | 6 | Mode (bits 5:3) and register (bits 2:0) field |
| op_size | input | 4 | Operand size in bytes |
| ext_data | input | 16 | Extension word from the stream |
| ext_valid | input | 1 | Extension word is present |
| ext_ready | output | 1 | Decoder will take a word this cycle |
| reg_num | output | 4 | Register number |
| ea_flags | output | 8 | Class flags, bit layout above |
| disp | output | 32 | Sign-extended displacement or absolute address |
| imm_data | output | 96 | Immediate words, group 0 in the low 32 bits |
| ext_bytes | output | 4 | Extension bytes consumed |
| done | output | 1 | One-cycle end of a legal decode |
| err | output | 1 | One-cycle illegal-mode indication |

## Verification
The bench sends 0x8000 and 0xFFF0 as 16-bit values and 0x12F0 as a byte immediate. A design that zero-extended them, or used the wrong byte, would report a small positive number. It covers immediates of 4, 8 and 12 bytes with stalls in `ext_valid`. A design that miscounted groups would hang or finish early with the wrong byte count, and one that swapped word halves would show reversed data. It also raises `start` in the middle of a fetch and drives valid words while idle. A design that honoured either would restart or swallow a word, and the later results would differ. The illegal mode-7 fields are checked to end with `err` and zeroed outputs, not a `done`.

// File: rtl/ea_pkg.sv
// Package: shared types for the effective address decoder.
// Assumes a 16-bit extension word and a 32-bit data word.
package ea_pkg;

    // Class flags; the first member is the most significant bit.
    typedef struct packed {
        logic predec;
        logic postinc;
        logic pcrel;
        logic indexed;
        logic offset;
        logic absolute;
        logic immed;
        logic direct;
    } ea_flags_t;

    // How the collected extension words are turned into results.
    typedef enum logic [2:0] {
        K_NONE,
        K_DISP_W,
        K_DISP_L,
        K_IMM_B,
        K_IMM_W,
        K_IMM_L
    } ea_kind_t;

    // Sequencer state.
    typedef enum logic {
        ST_IDLE,
        ST_FETCH
    } ea_state_t;

endpackage

// File: rtl/ea_mode_decode.sv
// Module: ea_mode_decode
// Purely combinational decode of the mode/register field and operand size.
// It gives the register number, flags, the result kind and the number of
// extension words owed. Assumes WPD extension words per data word.
module ea_mode_decode
    import ea_pkg::*;
#(
    parameter int SIZE_W = 4,
    parameter int WPD    = 2,
    parameter int CNT_W  = 3
) (
    input  logic [5:0]        mode_reg,
    input  logic [SIZE_W-1:0] op_size,
    output logic [3:0]        reg_num,
    output ea_flags_t         flags,
    output ea_kind_t          kind,
    output logic [CNT_W-1:0]  nwords,
    output logic              illegal
);

    logic [2:0] mode;
    logic [2:0] rlow;

    assign mode = mode_reg[5:3];
    assign rlow = mode_reg[2:0];

    // Classify the field; immediate is tested ahead of the memory modes.
    always_comb begin
        reg_num = '0;
        flags   = '0;
        kind    = K_NONE;
        nwords  = '0;
        illegal = 1'b0;
        if (mode_reg[5:4] == 2'b00) begin
            reg_num      = mode_reg[3:0];
            flags.direct = 1'b1;
        end else if (mode_reg == 6'b111100) begin
            reg_num     = {1'b0, rlow};
            flags.immed = 1'b1;
            if (op_size <= SIZE_W'(1)) begin
                kind   = K_IMM_B;
                nwords = CNT_W'(1);
            end else if (op_size <= SIZE_W'(2)) begin
                kind   = K_IMM_W;
                nwords = CNT_W'(1);
            end else begin
                kind = K_IMM_L;
                if (op_size <= SIZE_W'(4))      nwords = CNT_W'(WPD);
                else if (op_size <= SIZE_W'(8)) nwords = CNT_W'(2 * WPD);
                else                            nwords = CNT_W'(3 * WPD);
            end
        end else begin
            reg_num = {1'b1, rlow};
            case (mode)
                3'd3: flags.postinc = 1'b1;
                3'd4: flags.predec  = 1'b1;
                3'd5: begin
                    flags.offset = 1'b1;
                    kind         = K_DISP_W;
                    nwords       = CNT_W'(1);
                end
                3'd6: flags.indexed = 1'b1;
                3'd7: begin
                    reg_num = {1'b0, rlow};
                    case (rlow)
                        3'd0: begin
                            flags.absolute = 1'b1;
                            kind           = K_DISP_W;
                            nwords         = CNT_W'(1);
                        end
                        3'd1: begin
                            flags.absolute = 1'b1;
                            kind           = K_DISP_L;
                            nwords         = CNT_W'(2);
                        end
                        3'd2: begin
                            flags.pcrel  = 1'b1;
                            flags.offset = 1'b1;
                            kind         = K_DISP_W;
                            nwords       = CNT_W'(1);
                        end
                        3'd3: begin
                            flags.pcrel   = 1'b1;
                            flags.indexed = 1'b1;
                        end
                        default: begin
                            reg_num = '0;
                            illegal = 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ea_ext_collect.sv
// Module: ea_ext_collect
// Shift register that gathers extension words, newest in the low bits,
// and counts them. Assumes the caller never takes more than MAXW words.
module ea_ext_collect #(
    parameter int EXT_W = 16,
    parameter int MAXW  = 6,
    parameter int CNT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  take,
    input  logic [EXT_W-1:0]      word,
    output logic [MAXW*EXT_W-1:0] sr,
    output logic [CNT_W-1:0]      count
);

    // Shift in an accepted word, or clear at the start of a decode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr    <= '0;
            count <= '0;
        end else if (take) begin
            sr    <= {sr[(MAXW-1)*EXT_W-1:0], word};
            count <= count + CNT_W'(1);
        end
    end

    // R9: a word is never taken once the buffer is full.
    assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (count < CNT_W'(MAXW)));

endmodule

// File: rtl/ea_decoder.sv
// Module: ea_decoder (top)
// Decodes an operand mode/register field and fetches its extension words
// over a valid/ready stream. It reports the results with a done or err pulse.
// Assumes EXT_W divides DATA_W and that start is a single-cycle pulse.
module ea_decoder
    import ea_pkg::*;
#(
    parameter int EXT_W     = 16,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 4,
    parameter int IMM_WORDS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [5:0]                  mode_reg,
    input  logic [SIZE_W-1:0]           op_size,
    input  logic [EXT_W-1:0]            ext_data,
    input  logic                        ext_valid,
    output logic                        ext_ready,
    output logic [3:0]                  reg_num,
    output logic [7:0]                  ea_flags,
    output logic [DATA_W-1:0]           disp,
    output logic [IMM_WORDS*DATA_W-1:0] imm_data,
    output logic [$clog2(IMM_WORDS*DATA_W/8+1)-1:0] ext_bytes,
    output logic                        done,
    output logic                        err
);

    localparam int WPD     = DATA_W / EXT_W;
    localparam int MAXW    = IMM_WORDS * WPD;
    localparam int CNT_W   = $clog2(MAXW + 1);
    localparam int BYTES_W = $clog2(IMM_WORDS * DATA_W / 8 + 1);
    localparam int BPW     = EXT_W / 8;

    logic [3:0]             dec_reg;
    ea_flags_t              dec_flags;
    ea_kind_t               dec_kind;
    logic [CNT_W-1:0]       dec_nwords;
    logic                   dec_illegal;

    ea_state_t              state;
    logic [3:0]             reg_q;
    ea_flags_t              flags_q;
    ea_kind_t               kind_q;
    logic [CNT_W-1:0]       nwords_q;
    logic [BYTES_W-1:0]     bytes_q;
    logic                   done_q;
    logic                   err_q;

    logic                   start_ok;
    logic                   take;
    logic [MAXW*EXT_W-1:0]  sr;
    logic [CNT_W-1:0]       word_cnt;
    logic [DATA_W-1:0]      imm_w [IMM_WORDS];

    ea_mode_decode #(.SIZE_W(SIZE_W), .WPD(WPD), .CNT_W(CNT_W)) u_dec (
        .mode_reg (mode_reg),
        .op_size  (op_size),
        .reg_num  (dec_reg),
        .flags    (dec_flags),
        .kind     (dec_kind),
        .nwords   (dec_nwords),
        .illegal  (dec_illegal)
    );

    assign start_ok  = start && (state == ST_IDLE);
    assign ext_ready = (state == ST_FETCH);
    assign take      = ext_ready && ext_valid;

    ea_ext_collect #(.EXT_W(EXT_W), .MAXW(MAXW), .CNT_W(CNT_W)) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_ok),
        .take  (take),
        .word  (ext_data),
        .sr    (sr),
        .count (word_cnt)
    );

    // Sequencer: latch the decode on start, count words, raise done or err.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            reg_q    <= '0;
            flags_q  <= '0;
            kind_q   <= K_NONE;
            nwords_q <= '0;
            bytes_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    reg_q    <= dec_reg;
                    flags_q  <= dec_flags;
                    kind_q   <= dec_kind;
                    nwords_q <= dec_nwords;
                    bytes_q  <= BYTES_W'(int'(dec_nwords) * BPW);
                    if (dec_illegal)                err_q  <= 1'b1;
                    else if (dec_nwords == '0)      done_q <= 1'b1;
                    else                            state  <= ST_FETCH;
                end
                ST_FETCH: if (ext_valid && (word_cnt + CNT_W'(1) == nwords_q)) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Displacement / absolute address formatting from the collected words.
    always_comb begin
        case (kind_q)
            K_DISP_W: disp = {{(DATA_W-EXT_W){sr[EXT_W-1]}}, sr[EXT_W-1:0]};
            K_DISP_L: disp = sr[DATA_W-1:0];
            default:  disp = '0;
        endcase
    end

    // Immediate formatting: one formatter per 32-bit result word.
    for (genvar g = 0; g < IMM_WORDS; g++) begin : g_imm
        always_comb begin
            int grp;
            int idx;
            grp      = int'(nwords_q) / WPD;
            idx      = grp - 1 - g;
            imm_w[g] = '0;
            if (g == 0 && kind_q == K_IMM_B)
                imm_w[g] = {{(DATA_W-8){sr[7]}}, sr[7:0]};
            else if (g == 0 && kind_q == K_IMM_W)
                imm_w[g] = {{(DATA_W-EXT_W){sr[EXT_W-1]}}, sr[EXT_W-1:0]};
            else if (kind_q == K_IMM_L && g < grp)
                imm_w[g] = sr[idx*DATA_W +: DATA_W];
        end
        assign imm_data[g*DATA_W +: DATA_W] = imm_w[g];
    end

    assign reg_num   = reg_q;
    assign ea_flags  = flags_q;
    assign ext_bytes = bytes_q;
    assign done      = done_q;
    assign err       = err_q;

    // R10: done and err never appear together.
    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R10: the reported byte count matches the words actually taken.
    assert_bytes_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ext_bytes == BYTES_W'(int'(word_cnt) * BPW)));

    // R5: an illegal decode reports no class and no bytes.
    assert_err_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (ea_flags == 8'h00 && ext_bytes == '0 && reg_num == 4'h0));

    // R3: at most one addressing class is flagged by the field decode.
    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $onehot0({dec_flags.direct, dec_flags.immed, dec_flags.absolute,
                            dec_flags.offset, dec_flags.indexed,
                            dec_flags.postinc, dec_flags.predec}));

    // R12: with no start and nothing owed, results stay put.
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_ready && !start) |=> ($stable(ea_flags) && $stable(reg_num) &&
                                    $stable(ext_bytes)));

endmodule

// File: tb/sim_ea_decoder.sv
`timescale 1ns/1ps
module sim_ea_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  mode_reg = '0;
    logic [3:0]  op_size = '0;
    logic [15:0] ext_data = '0;
    logic        ext_valid = 1'b0;
    logic        ext_ready;
    logic [3:0]  reg_num;
    logic [7:0]  ea_flags;
    logic [31:0] disp;
    logic [95:0] imm_data;
    logic [3:0]  ext_bytes;
    logic        done;
    logic        err;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit          is_err;
        logic [3:0]  rn;
        logic [7:0]  fl;
        logic [31:0] dsp;
        logic [95:0] imm;
        int          bytes;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t last;

    always #2 clk = ~clk;

    ea_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_reg(mode_reg),
        .op_size(op_size), .ext_data(ext_data), .ext_valid(ext_valid),
        .ext_ready(ext_ready), .reg_num(reg_num), .ea_flags(ea_flags),
        .disp(disp), .imm_data(imm_data), .ext_bytes(ext_bytes),
        .done(done), .err(err)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [5:0] m, input int sz, input logic [95:0] w);
        exp_t e;
        int grp;
        e.is_err = 0; e.rn = 0; e.fl = 0; e.dsp = 0; e.imm = 0; e.bytes = 0; e.tag = "";
        if (m[5:4] == 2'b00) begin
            e.rn = m[3:0]; e.fl = 8'h01;
        end else if (m == 6'b111100) begin
            e.rn = 4'd4; e.fl = 8'h02;
            if (sz <= 1) begin
                e.bytes = 2; e.imm[31:0] = {{24{w[7]}}, w[7:0]};
            end else if (sz <= 2) begin
                e.bytes = 2; e.imm[31:0] = {{16{w[15]}}, w[15:0]};
            end else begin
                grp = (sz <= 4) ? 1 : (sz <= 8) ? 2 : 3;
                e.bytes = grp * 4;
                for (int k = 0; k < grp; k++)
                    e.imm[32*k +: 32] = {w[32*k +: 16], w[32*k+16 +: 16]};
            end
        end else begin
            e.rn = {1'b1, m[2:0]};
            case (m[5:3])
                3'd3: e.fl = 8'h40;
                3'd4: e.fl = 8'h80;
                3'd5: begin e.fl = 8'h08; e.bytes = 2; e.dsp = {{16{w[15]}}, w[15:0]}; end
                3'd6: e.fl = 8'h10;
                3'd7: begin
                    e.rn = {1'b0, m[2:0]};
                    case (m[2:0])
                        3'd0: begin e.fl = 8'h04; e.bytes = 2; e.dsp = {{16{w[15]}}, w[15:0]}; end
                        3'd1: begin e.fl = 8'h04; e.bytes = 4; e.dsp = {w[15:0], w[31:16]}; end
                        3'd2: begin e.fl = 8'h28; e.bytes = 2; e.dsp = {{16{w[15]}}, w[15:0]}; end
                        3'd3: e.fl = 8'h30;
                        default: begin e.is_err = 1; e.rn = 0; end
                    endcase
                end
                default: ;
            endcase
        end
        return e;
    endfunction

    // Driver: push the expectation, pulse start, feed words with optional stalls.
    task automatic run(input logic [5:0] m, input int sz, input logic [95:0] w,
                       input bit gap, input bit poke, input string tag);
        exp_t e;
        int n;
        bit tog;
        e = model(m, sz, w);
        e.tag = tag;
        q.push_back(e);
        last = e;
        n = e.is_err ? 0 : e.bytes / 2;
        @(negedge clk);
        start = 1'b1; mode_reg = m; op_size = sz[3:0];
        @(negedge clk);
        start = 1'b0;
        tog = gap;
        for (int i = 0; i < n; ) begin
            if (tog) begin
                ext_valid = 1'b0;
                start     = poke;
                mode_reg  = 6'o00;
            end else begin
                start     = 1'b0;
                ext_valid = 1'b1;
                ext_data  = w[16*i +: 16];
                if (ext_ready) i++;
            end
            if (gap) tog = !tog;
            @(negedge clk);
        end
        ext_valid = 1'b0;
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each done/err against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && (done || err)) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected result pulse: done=%0b err=%0b expected none", done, err);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (err !== e.is_err || done !== !e.is_err || reg_num !== e.rn ||
                    ea_flags !== e.fl || disp !== e.dsp || imm_data !== e.imm ||
                    ext_bytes !== 4'(e.bytes)) begin
                    fails++;
                    $display("FAIL %s: got err=%0b reg=%0d flags=%h disp=%h imm=%h bytes=%0d; expected err=%0b reg=%0d flags=%h disp=%h imm=%h bytes=%0d",
                             e.tag, err, reg_num, ea_flags, disp, imm_data, ext_bytes,
                             e.is_err, e.rn, e.fl, e.dsp, e.imm, e.bytes);
                end
            end
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state.
        checks++;
        if (done !== 0 || err !== 0 || ext_ready !== 0 || ea_flags !== 0 ||
            reg_num !== 0 || disp !== 0 || imm_data !== 0 || ext_bytes !== 0) begin
            fails++;
            $display("FAIL R11 reset: done=%0b err=%0b ready=%0b flags=%h expected all zero",
                     done, err, ext_ready, ea_flags);
        end
        rst_n = 1'b1;
        @(negedge clk);

        run(6'o03, 4, 96'h0, 0, 0, "R1 data reg 3");
        run(6'o15, 4, 96'h0, 0, 0, "R1 address reg 13");
        run(6'o22, 4, 96'h0, 0, 0, "R3 indirect");
        run(6'o37, 4, 96'h0, 0, 0, "R3 postincrement");
        run(6'o41, 4, 96'h0, 0, 0, "R3 predecrement");
        run(6'o56, 4, 96'h0000_FFF0, 0, 0, "R3 R6 displacement negative");
        run(6'o60, 4, 96'h0, 0, 0, "R3 indexed");
        run(6'o70, 4, 96'h0000_8000, 0, 0, "R4 R6 absolute word");
        run(6'o71, 4, 96'h5678_1234, 1, 0, "R4 R6 absolute long with stalls");
        run(6'o72, 4, 96'h0000_0010, 0, 0, "R4 pc-relative displacement");
        run(6'o73, 4, 96'h0, 0, 0, "R4 pc-relative indexed");
        run(6'o75, 4, 96'h0, 0, 0, "R5 illegal reg 5");
        run(6'o77, 4, 96'h0, 0, 0, "R5 illegal reg 7");
        run(6'o74, 1, 96'h0000_12F0, 0, 0, "R2 R7 byte immediate");
        run(6'o74, 2, 96'h0000_7FFF, 0, 0, "R7 word immediate");
        run(6'o74, 4, 96'h0000_BEEF_DEAD, 0, 0, "R8 long immediate");
        run(6'o74, 8, 96'h4444_3333_2222_1111, 1, 0, "R8 two groups stalled");
        run(6'o74, 12, 96'h6666_5555_4444_3333_2222_1111, 1, 1, "R8 R10 three groups, start while busy");

        // R12: results hold after done with no new start.
        repeat (3) @(negedge clk);
        checks++;
        if (ea_flags !== last.fl || imm_data !== last.imm || ext_bytes !== 4'(last.bytes)) begin
            fails++;
            $display("FAIL R12 hold: flags=%h imm=%h bytes=%0d expected flags=%h imm=%h bytes=%0d",
                     ea_flags, imm_data, ext_bytes, last.fl, last.imm, last.bytes);
        end

        // R9: valid words while idle are not accepted.
        ext_valid = 1'b1; ext_data = 16'hFFFF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            checks++;
            if (ext_ready !== 1'b0) begin
                fails++;
                $display("FAIL R9 ready while idle: got %0b expected 0", ext_ready);
            end
        end
        ext_valid = 1'b0;
        run(6'o55, 4, 96'h0000_0123, 0, 0, "R9 word after idle traffic");

        @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing results: got %0d pending expected 0", q.size());
        end
        summary();
    end

endmodule